// File: doc/BRIEF.md
# Cartridge ROM Bus Cycle Sequencer

This block sits between a host command port and the parallel program-ROM bus of a game cartridge. The host can load a CPU-space start address, ask for one read, ask for one write, or ask for a burst of reads. For each bus access the block places the address, the read/write level and any write data on the pins first. It then raises the M2 strobe for a fixed window and lowers it again while the address is still held. The active-low chip enable is derived from address bit 15 and the strobe, so it is asserted only inside that window and only for the upper half of CPU space.

Read bytes are captured while the strobe is high and returned with a one-cycle valid pulse. After each read the low address bits advance by one. A whole 4 KiB block can therefore be dumped from a single loaded base: $8000, then $9000, and so on. Eight such bursts cover a 32 KiB program space.

Top module: `cart_bus_seq`

## Requirements
- R1: After synchronous reset, busy, rd_valid and done are 0. m2 is 0, ce_n is 1, cart_rw is 1 and cart_doe is 0.
- R2: ce_n equals NOT(address bit 15 AND m2). It is high whenever m2 is low, and stays high for every access whose address has bit 15 clear.
- R3: Each access spans SETUP_CYC cycles with m2 low and the address, cart_rw and write data already valid. These are followed by STROBE_CYC cycles with m2 high, then HOLD_CYC cycles with m2 low and the address still held. For a single read, rd_valid rises in cycle SETUP_CYC+STROBE_CYC+1, counting the first cycle after the accepting edge as 1.
- R4: rd_data is the cart_din value present in the last strobe cycle. rd_valid is a one-cycle pulse per byte.
- R5: A write (cmd_op 2'b10) drives cmd_wdata on cart_dout, with cart_doe high and cart_rw low, from setup through hold. It leaves the address unchanged.
- R6: cart_addr bit n carries address register bit n for every n in 0..14, with no reordering.
- R7: After each read, the low 12 address bits increase by one and wrap within the 4096-byte block. Bits 15..12 are unchanged.
- R8: A burst (cmd_op 2'b11) with count N>0 performs N reads back to back, one every SETUP_CYC+STROBE_CYC+HOLD_CYC cycles. done pulses in the cycle after the last hold phase, and single reads and writes end with done the same way. A count of 0 pulses done in cycle 1 and runs no bus access.
- R9: busy is high from the cycle after an access command is accepted until the command ends. Any command presented while busy is ignored.
- R10: Between accesses, m2 is low, ce_n is high, cart_rw is high and cart_doe is low.
- R11: A load (cmd_op 2'b00) sets the address from cmd_addr. It does not raise busy or done and runs no bus access. A single read (cmd_op 2'b01) uses the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, accepted when not busy |
| cmd_op | input | 2 | 00 load, 01 read, 10 write, 11 burst read |
| cmd_addr | input | 16 | CPU-space address for load |
| cmd_wdata | input | 8 | Write byte |
| cmd_len | input | 13 | Burst byte count |
| busy | output | 1 | Command in progress |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | One-cycle pulse with rd_data |
| done | output | 1 | One-cycle pulse at command end |
| cart_addr | output | 15 | Cartridge address lines 0..14 |
| cart_din | input | 8 | Data bus from cartridge |
| cart_dout | output | 8 | Data bus toward cartridge |
| cart_doe | output | 1 | Data bus output enable |
| cart_rw | output | 1 | 1 read, 0 write |
| m2 | output | 1 | Access strobe |
| ce_n | output | 1 | Active-low ROM chip enable |

## Verification
The hardest situation to reach is a command arriving while an access is in progress. It must leave neither the address counter nor the burst count changed. The stimulus holds a load to a far address and a read on the command port for several cycles in the middle of a burst, then checks that the next read continues from where the burst stopped. The wrap of the low twelve bits is reached with a full 4096-byte burst from $F000, followed by a read that must return the byte at $F000 again. Random mixes of loads, reads, writes and short bursts, some of them below $8000, cover the chip-enable gating.

// File: rtl/cart_seq_pkg.sv
package cart_seq_pkg;

    localparam int CPU_AW = 16;
    localparam int CART_AW = 15;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_BURST = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic              is_write;
        logic [BYTE_W-1:0] wdata;
    } xfer_t;

    // chip enable is active low and only inside the strobe of an upper-half access
    function automatic logic ce_level(input logic a_top, input logic strobe);
        return ~(a_top & strobe);
    endfunction

endpackage

// File: rtl/cart_phase_timer.sv
module cart_phase_timer #(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/cart_addr_ctr.sv
module cart_addr_ctr
    import cart_seq_pkg::*;
#(
    parameter int INC_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CPU_AW-1:0] load_addr,
    input  logic              inc,
    output logic [CPU_AW-1:0] addr
);
    logic [CPU_AW-1:0] addr_q;
    logic [CPU_AW-1:0] addr_nxt;

    generate
        if (INC_W >= CPU_AW) begin : g_full
            assign addr_nxt = addr_q + CPU_AW'(1);
        end else begin : g_split
            // only the low block bits count; the block base stays put
            assign addr_nxt = {addr_q[CPU_AW-1:INC_W], addr_q[INC_W-1:0] + INC_W'(1)};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_addr;
        end else if (inc) begin
            addr_q <= addr_nxt;
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/cart_pin_drive.sv
module cart_pin_drive
    import cart_seq_pkg::*;
(
    input  phase_e             phase,
    input  xfer_t              xf,
    input  logic [CPU_AW-1:0]  addr,
    output logic [CART_AW-1:0] cart_addr,
    output logic [BYTE_W-1:0]  cart_dout,
    output logic               cart_doe,
    output logic               cart_rw,
    output logic               m2,
    output logic               ce_n
);
    logic drive;

    assign m2        = (phase == PH_STROBE);
    assign ce_n      = ce_level(addr[CPU_AW-1], m2);
    assign drive     = xf.is_write && (phase != PH_IDLE);
    assign cart_doe  = drive;
    assign cart_rw   = ~drive;
    assign cart_dout = drive ? xf.wdata : '0;

    // straight, bit-for-bit address mapping
    for (genvar n = 0; n < CART_AW; n++) begin : g_abit
        assign cart_addr[n] = addr[n];
    end
endmodule

// File: rtl/cart_bus_seq.sv
module cart_bus_seq
    import cart_seq_pkg::*;
#(
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 4,
    parameter int HOLD_CYC   = 2,
    parameter int INC_W      = 12,
    parameter int LEN_W      = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [CPU_AW-1:0]  cmd_addr,
    input  logic [BYTE_W-1:0]  cmd_wdata,
    input  logic [LEN_W-1:0]   cmd_len,
    output logic               busy,
    output logic [BYTE_W-1:0]  rd_data,
    output logic               rd_valid,
    output logic               done,
    output logic [CART_AW-1:0] cart_addr,
    input  logic [BYTE_W-1:0]  cart_din,
    output logic [BYTE_W-1:0]  cart_dout,
    output logic               cart_doe,
    output logic               cart_rw,
    output logic               m2,
    output logic               ce_n
);
    localparam int MAX_A = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
    localparam int TW    = $clog2(MAX_C) + 1;

    phase_e             phase_q, phase_nxt;
    xfer_t              xf_q;
    logic [LEN_W-1:0]   remain_q;
    logic [BYTE_W-1:0]  rd_data_q;
    logic               rd_valid_q, done_q;
    logic [CPU_AW-1:0]  addr;
    logic               tmr_load, tmr_exp;
    logic [TW-1:0]      tmr_val;
    logic               accept, starts_bus, last_beat;
    op_e                op;

    assign op         = op_e'(cmd_op);
    assign accept     = cmd_valid && (phase_q == PH_IDLE);
    assign starts_bus = (op == OP_READ) || (op == OP_WRITE) ||
                        ((op == OP_BURST) && (cmd_len != '0));
    assign last_beat  = (remain_q == LEN_W'(1));

    always_comb begin
        phase_nxt = phase_q;
        unique case (phase_q)
            PH_IDLE:   if (accept && starts_bus) phase_nxt = PH_SETUP;
            PH_SETUP:  if (tmr_exp) phase_nxt = PH_STROBE;
            PH_STROBE: if (tmr_exp) phase_nxt = PH_HOLD;
            PH_HOLD:   if (tmr_exp) phase_nxt = last_beat ? PH_IDLE : PH_SETUP;
            default:   phase_nxt = PH_IDLE;
        endcase
        tmr_load = (phase_nxt != phase_q);
        unique case (phase_nxt)
            PH_SETUP:  tmr_val = TW'(SETUP_CYC - 1);
            PH_STROBE: tmr_val = TW'(STROBE_CYC - 1);
            PH_HOLD:   tmr_val = TW'(HOLD_CYC - 1);
            default:   tmr_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            xf_q       <= '0;
            remain_q   <= '0;
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            phase_q    <= phase_nxt;
            rd_valid_q <= 1'b0;
            done_q     <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        unique case (op)
                            OP_READ: begin
                                xf_q     <= '0;
                                remain_q <= LEN_W'(1);
                            end
                            OP_WRITE: begin
                                xf_q     <= '{is_write: 1'b1, wdata: cmd_wdata};
                                remain_q <= LEN_W'(1);
                            end
                            OP_BURST: begin
                                xf_q     <= '0;
                                remain_q <= cmd_len;
                                if (cmd_len == '0) done_q <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                PH_STROBE: begin
                    if (tmr_exp && !xf_q.is_write) begin
                        rd_data_q  <= cart_din;
                        rd_valid_q <= 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (tmr_exp) begin
                        if (last_beat) begin
                            done_q <= 1'b1;
                            xf_q   <= '0;
                        end
                        remain_q <= remain_q - LEN_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    cart_phase_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    cart_addr_ctr #(.INC_W(INC_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (accept && (op == OP_LOAD)),
        .load_addr (cmd_addr),
        .inc       ((phase_q == PH_HOLD) && tmr_exp && !xf_q.is_write),
        .addr      (addr)
    );

    cart_pin_drive u_pins (
        .phase     (phase_q),
        .xf        (xf_q),
        .addr      (addr),
        .cart_addr (cart_addr),
        .cart_dout (cart_dout),
        .cart_doe  (cart_doe),
        .cart_rw   (cart_rw),
        .m2        (m2),
        .ce_n      (ce_n)
    );

    assign busy     = (phase_q != PH_IDLE);
    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;
    assign done     = done_q;
endmodule

// File: rtl/cart_bus_seq_chk.sv
module cart_bus_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        rd_valid,
    input logic        done,
    input logic [14:0] cart_addr,
    input logic [7:0]  cart_dout,
    input logic        cart_doe,
    input logic        cart_rw,
    input logic        m2,
    input logic        ce_n
);
    // R2: enable never active outside the strobe
    p_ce_in_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        !ce_n |-> m2);

    // R3: address and direction already settled when the strobe rises
    p_setup_before_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(m2) |-> ($stable(cart_addr) && $stable(cart_rw) && $stable(cart_dout)));

    // R3: nothing moves while the strobe stays high
    p_stable_in_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        (m2 && $past(m2)) |-> ($stable(cart_addr) && $stable(cart_rw) && $stable(cart_dout)));

    // R3: address still held on the first cycle after the strobe falls
    p_hold_after_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(m2) |-> ($stable(cart_addr) && $stable(cart_rw)));

    // R4: read valid is a single-cycle pulse
    p_rdvalid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R5: bus is driven exactly when writing
    p_write_drive_r5: assert property (@(posedge clk) disable iff (rst)
        cart_doe == !cart_rw);

    // R10: quiet bus between accesses
    p_idle_levels_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!m2 && ce_n && cart_rw && !cart_doe));

    // R8: completion is reported with the block already idle
    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind cart_bus_seq cart_bus_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .done      (done),
    .cart_addr (cart_addr),
    .cart_dout (cart_dout),
    .cart_doe  (cart_doe),
    .cart_rw   (cart_rw),
    .m2        (m2),
    .ce_n      (ce_n)
);

// File: tb/cart_bus_seq_bench.sv
module cart_bus_seq_bench;
    localparam int S = 2;
    localparam int P = 4;
    localparam int H = 2;
    localparam int PER = S + P + H;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [15:0] cmd_addr = '0;
    logic [7:0]  cmd_wdata = '0;
    logic [12:0] cmd_len = '0;
    logic        busy, rd_valid, done, cart_doe, cart_rw, m2, ce_n;
    logic [7:0]  rd_data, cart_dout, cart_din;
    logic [14:0] cart_addr;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc;
    int cycles_total = 0;
    bit finished = 0;
    logic [15:0] exp_addr = '0;
    int viol_ce = 0, viol_len = 0, strobe_run = 0;
    logic [14:0] wcap_addr;
    logic [7:0]  wcap_data;
    logic        wcap_doe;

    always #4 clk = ~clk;

    cart_bus_seq #(.SETUP_CYC(S), .STROBE_CYC(P), .HOLD_CYC(H)) u_cart_bus_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_len(cmd_len),
        .busy(busy), .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
        .cart_addr(cart_addr), .cart_din(cart_din), .cart_dout(cart_dout),
        .cart_doe(cart_doe), .cart_rw(cart_rw), .m2(m2), .ce_n(ce_n)
    );

    function automatic logic [7:0] rom(input logic [14:0] a);
        return (a[7:0] + {1'b0, a[14:8]} * 8'd37) ^ 8'hA5;
    endfunction

    function automatic logic [7:0] model_rd(input logic [15:0] a);
        return a[15] ? rom(a[14:0]) : 8'hFF;
    endfunction

    function automatic logic [15:0] bump(input logic [15:0] a);
        return {a[15:12], a[11:0] + 12'd1};
    endfunction

    // cartridge model: drives data only while selected
    assign cart_din = !ce_n ? rom(cart_addr) : 8'hFF;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (ce_n != ~(exp_addr[15] & m2)) viol_ce++;
            if (m2) strobe_run++;
            else begin
                if (strobe_run != 0 && strobe_run != P) viol_len++;
                strobe_run = 0;
            end
            if (m2 && !cart_rw) begin
                wcap_addr = cart_addr;
                wcap_data = cart_dout;
                wcap_doe  = cart_doe;
            end
        end
    end

    task automatic send(input logic [1:0] op, input logic [15:0] a,
                        input logic [7:0] wd, input logic [12:0] len);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = wd; cmd_len = len;
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 1;
    endtask

    task automatic do_load(input logic [15:0] a);
        send(2'b00, a, 8'h00, 13'd0);
        chk(!busy && !done && !m2, "R11 load idle", {busy, done, m2}, 0);
        exp_addr = a;
    endtask

    task automatic wait_done(input int expc, input string tag);
        while (!done && cyc < 40000) begin @(negedge clk); cyc++; end
        chk(cyc == expc, tag, cyc, expc);
    endtask

    task automatic do_burst(input int n, input string tag);
        send(2'b11, 16'h0, 8'h00, 13'(n));
        for (int i = 0; i < n; i++) begin
            while (!rd_valid && cyc < 40000) begin @(negedge clk); cyc++; end
            chk(cyc == S + P + 1 + i * PER, {tag, " R3 R8 timing"}, cyc, S + P + 1 + i * PER);
            chk(rd_data == model_rd(exp_addr), {tag, " R4 R7 data"}, rd_data, model_rd(exp_addr));
            exp_addr = bump(exp_addr);
            @(negedge clk); cyc++;
        end
        wait_done(n * PER + 1, {tag, " R8 done"});
    endtask

    task automatic do_read(input string tag);
        send(2'b01, 16'h0, 8'h00, 13'd0);
        chk(busy, "R9 busy", busy, 1);
        while (!rd_valid && cyc < 40000) begin @(negedge clk); cyc++; end
        chk(cyc == S + P + 1, {tag, " R3 latency"}, cyc, S + P + 1);
        chk(rd_data == model_rd(exp_addr), {tag, " R4 data"}, rd_data, model_rd(exp_addr));
        exp_addr = bump(exp_addr);
        wait_done(PER + 1, {tag, " R8 done"});
    endtask

    task automatic do_write(input logic [7:0] d);
        send(2'b10, 16'h0, d, 13'd0);
        wait_done(PER + 1, "R8 write done");
        chk(wcap_data == d && wcap_doe, "R5 write data", wcap_data, d);
        chk(wcap_addr == exp_addr[14:0], "R5 R6 write addr", wcap_addr, exp_addr[14:0]);
        chk(cart_rw && !cart_doe, "R10 idle after write", {cart_rw, cart_doe}, 2);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!busy && !rd_valid && !done, "R1 reset flags", {busy, rd_valid, done}, 0);
        chk(!m2 && ce_n && cart_rw && !cart_doe, "R1 reset pins", {m2, ce_n, cart_rw, cart_doe}, 6);
        rst = 1'b0;

        // R6 R11: single reads at asymmetric addresses
        do_load(16'h8001); do_read("R6 a8001");
        do_load(16'hC000); do_read("R6 ac000");
        do_load(16'h8000); do_read("R11 a8000");
        do_read("R7 next");

        // R2: lower half never selects the ROM
        do_load(16'h1234); do_read("R2 low half");

        // R5: write leaves address unchanged
        do_load(16'h9ABC); do_write(8'h3C); do_read("R5 no inc");

        // R8: zero-length burst
        send(2'b11, 16'h0, 8'h00, 13'd0);
        chk(done && !busy, "R8 zero burst done", {done, busy}, 2);
        repeat (10) begin @(negedge clk); chk(!m2 && !rd_valid, "R8 zero burst no access", m2, 0); end

        // R9: commands during a burst are ignored
        do_load(16'hA010);
        send(2'b11, 16'h0, 8'h00, 13'd3);
        cmd_valid = 1'b1; cmd_op = 2'b00; cmd_addr = 16'h0F00;
        repeat (4) @(negedge clk);
        cmd_op = 2'b01;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(!busy, "R9 ended", busy, 0);
        exp_addr = 16'hA013;
        do_read("R9 continue");

        // R7: full block with wrap
        do_load(16'hF000); do_burst(4096, "R7 full");
        do_read("R7 wrap");

        // random mix
        for (int k = 0; k < 60; k++) begin
            int sel = $urandom_range(0, 3);
            if ($urandom_range(0, 1) == 1)
                do_load({($urandom_range(0, 4) != 0), 15'($urandom)});
            case (sel)
                0: do_read("R4 rnd");
                1: do_write(8'($urandom));
                default: do_burst($urandom_range(1, 12), "R8 rnd");
            endcase
        end

        chk(viol_ce == 0, "R2 enable gating", viol_ce, 0);
        chk(viol_len == 0, "R3 strobe width", viol_len, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles_total++;
        if (cycles_total > 190000 && !finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles_total, 190000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule